// File: doc/BRIEF.md
# Battery Health Check Scheduler

This block decides when a backup cell gets tested, and it keeps the result of the last completed test. It watches a synchronous power-good level. Each time that level rises, the block starts a test. After that, it starts a new test at a fixed, long interval, for as long as power stays good. While power is absent, no test runs and the interval timer is idle.

A test has three steps:
- The block raises a request that turns on an external battery comparator.
- It waits a settling count.
- It captures the comparator's "below threshold" answer on a one-cycle sample strobe.

The captured answer drives an active-low battery-low output. Drive low means the battery is weak; drive high means release. The output is sticky: it changes only when a test completes. If power drops before the sample instant, the test is abandoned and the previous answer stays in place.

Both timing values are parameters in clock cycles. The default interval is one day of a 32768 Hz clock. A bench can use short values instead.

Top module: `batt_watch`

## Requirements
- R1: In the first cycle that `pwr_ok` is seen high after having been low (or after reset), `cmp_en` is still low. It is high from the next cycle on.
- R2: A test holds `cmp_en` high for exactly SETTLE_CYC consecutive cycles. `sample_stb` is high in the last of those cycles only, and never while `cmp_en` is low.
- R3: At the sample strobe, the flag takes the value of `batt_below`. From the next cycle, `batt_low_n` is 0 if `batt_below` was 1, and 1 if it was 0.
- R4: Between sample strobes, changes on `batt_below` have no effect on `batt_low_n`.
- R5: While `pwr_ok` stays high, the next test starts after a gap. `cmp_en` stays low for exactly INTERVAL_CYC cycles after a test ends, then goes high again.
- R6: While `pwr_ok` is low, `cmp_en` stays low from the following cycle on. The interval is restarted by the power-up test, so an outage in the middle of an interval gives a full INTERVAL_CYC gap after the power-up test.
- R7: If `pwr_ok` is low in any cycle of a test, including the sampling cycle, then:
  - no strobe is issued;
  - `cmp_en` falls in the next cycle;
  - `batt_low_n` keeps its earlier value.
- R8: During reset, `batt_low_n` is 1 and `cmp_en` and `sample_stb` are 0. If `pwr_ok` is high when reset is released, a test starts as in R1.
- R9: A low indication is removed only by a later completed test that samples `batt_below` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_ok | input | 1 | Supply-nominal flag, synchronous to `clk` |
| batt_below | input | 1 | Comparator result, 1 = battery under threshold |
| cmp_en | output | 1 | Request to power the battery comparator |
| sample_stb | output | 1 | One-cycle strobe at which `batt_below` is captured |
| batt_low_n | output | 1 | Battery-low indication, 0 = weak (pull low), 1 = release |

## Verification
The delicate coincidence is a supply drop that lands in the very cycle the sample strobe would fire. Both the abort path and the capture path then see the same clock edge. The bench sweeps the drop point over every cycle of a test, for both prior flag values, and drives `batt_below` opposite to the stored flag. It then judges the result:
- the strobe must stay low;
- the request must fall one cycle later;
- `batt_low_n` must keep its old level through the whole outage that follows.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } seq_st_t;
endpackage

// File: rtl/bmon_edge.sv
module bmon_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic pwr_rise
);
  logic pwr_q;
  logic pwr_d;

  always_comb begin
    pwr_d = pwr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= 1'b0;
    else        pwr_q <= pwr_d;
  end

  assign pwr_rise = pwr_ok & ~pwr_q;

  // R1: a power-up edge is a single-cycle event
  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rise |=> !pwr_rise);
endmodule

// File: rtl/bmon_interval.sv
module bmon_interval #(
  parameter int unsigned INTERVAL_CYC = 32'd2831155200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic done
);
  localparam int unsigned IW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL_CYC - 1);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | run;
    cnt_d  = cnt_q;
    if (clr)                cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run & (cnt_q == LAST);

  // R5: expiry restarts the count from zero
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0));
  // R6: with power away and no restart the timer does not move
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/bmon_seq.sv
module bmon_seq
  import bmon_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic pwr_rise,
  input  logic tick,
  output logic idle,
  output logic start,
  output logic cmp_en,
  output logic sample_stb
);
  localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  seq_st_t       st_q;
  seq_st_t       st_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign idle    = (st_q == ST_IDLE);
  assign start   = idle & (pwr_rise | tick);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_SETTLE;
          cnt_d = '0;
        end
      end
      ST_SETTLE: begin
        if (!pwr_ok || at_last) st_d  = ST_IDLE;
        else                    cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cmp_en     = (st_q == ST_SETTLE);
  assign sample_stb = cmp_en & pwr_ok & at_last;

  // R1: a power-up edge launches a test on the next cycle
  p_powerup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rise |=> cmp_en);
  // R2: the strobe only falls inside an active test
  p_stb_in_test_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> cmp_en);
  // R2: a strobe closes the test
  p_stb_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !cmp_en);
  // R6: no test survives a cycle without power
  p_off_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !cmp_en);
  // R7: no capture while power is absent
  p_off_no_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !sample_stb);
endmodule

// File: rtl/bmon_flag.sv
module bmon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic below,
  output logic low_n
);
  logic low_q;
  logic low_d;

  always_comb begin
    low_d = low_q;
    if (smp) low_d = below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   low_q <= 1'b0;
    else if (smp) low_q <= low_d;
  end

  assign low_n = ~low_q;

  // R3: the flag follows the comparator at the strobe
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp |=> (low_n == !$past(below)));
  // R4: the flag is sticky between strobes
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(low_n));
endmodule

// File: rtl/batt_watch.sv
module batt_watch #(
  parameter int unsigned INTERVAL_CYC = 32'd2831155200,
  parameter int unsigned SETTLE_CYC   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic batt_below,
  output logic cmp_en,
  output logic sample_stb,
  output logic batt_low_n
);
  logic pwr_rise;
  logic tick;
  logic idle;
  logic start;
  logic run;

  assign run = pwr_ok & idle;

  bmon_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .pwr_rise (pwr_rise)
  );

  bmon_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (start),
    .done  (tick)
  );

  bmon_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .pwr_rise   (pwr_rise),
    .tick       (tick),
    .idle       (idle),
    .start      (start),
    .cmp_en     (cmp_en),
    .sample_stb (sample_stb)
  );

  bmon_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .smp   (sample_stb),
    .below (batt_below),
    .low_n (batt_low_n)
  );

  // R2: starts are only taken while no test runs
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !cmp_en);
endmodule

// File: tb/batt_watch_test.sv
module batt_watch_test;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 3;
  localparam int IV = 20;

  logic clk;
  logic rst_n;
  logic pwr_ok;
  logic batt_below;
  logic cmp_en;
  logic sample_stb;
  logic batt_low_n;

  int n_vec;
  int n_bad;
  logic exp_low;

  batt_watch #(.INTERVAL_CYC(IV), .SETTLE_CYC(S)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .batt_below (batt_below),
    .cmp_en     (cmp_en),
    .sample_stb (sample_stb),
    .batt_low_n (batt_low_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic pw, input logic bb);
    @(negedge clk);
    pwr_ok     = pw;
    batt_below = bb;
    #1;
  endtask

  // next tick is the first cycle of a test
  task automatic run_test(input logic bb);
    for (int i = 1; i <= S; i++) begin
      tick(1'b1, bb);
      chk("R2 cmp_en in test", cmp_en, 1'b1);
      chk("R2 strobe position", sample_stb, (i == S));
      chk("R4 flag held in test", batt_low_n, ~exp_low);
    end
    exp_low = bb;
  endtask

  // n idle cycles with power good and comparator noise
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      tick(1'b1, i[0]);
      if (i == 0) chk("R3/R9 flag after strobe", batt_low_n, ~exp_low);
      chk("R5 no test in gap", cmp_en, 1'b0);
      chk("R4 flag sticky", batt_low_n, ~exp_low);
      chk("R2 no strobe in gap", sample_stb, 1'b0);
    end
  endtask

  task automatic outage(input int n, input logic bb);
    for (int i = 0; i < n; i++) begin
      tick(1'b0, bb);
      chk("R6 no test while off", cmp_en, 1'b0);
      chk("R7 flag kept while off", batt_low_n, ~exp_low);
    end
  endtask

  task automatic power_up(input logic bb);
    tick(1'b1, bb);
    chk("R1 request low at edge", cmp_en, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    exp_low = 1'b0;
    rst_n = 1'b0;
    pwr_ok = 1'b0;
    batt_below = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset batt_low_n", batt_low_n, 1'b1);
    chk("R8 reset cmp_en", cmp_en, 1'b0);
    chk("R8 reset strobe", sample_stb, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    outage(30, 1'b1);

    // first power-up, weak battery, then periodic test with good battery
    power_up(1'b1);
    run_test(1'b1);
    gap(IV);
    run_test(1'b0);
    gap(IV);

    // abort sweep: every cycle of a test, both prior flag values
    for (int k = 1; k <= S; k++) begin
      for (int f = 0; f < 2; f++) begin
        run_test(f[0]);
        gap(IV);
        for (int i = 1; i < k; i++) begin
          tick(1'b1, ~f[0]);
          chk("R7 test before drop", cmp_en, 1'b1);
          chk("R7 no strobe before drop", sample_stb, 1'b0);
        end
        tick(1'b0, ~f[0]);
        chk("R7 request at drop cycle", cmp_en, 1'b1);
        chk("R7 no strobe at drop", sample_stb, 1'b0);
        outage(IV + 5, ~f[0]);
        power_up(f[0]);
      end
    end

    // outage in the middle of an interval restarts the interval
    run_test(1'b1);
    gap(7);
    outage(5, 1'b0);
    power_up(1'b0);
    run_test(1'b0);
    gap(IV);
    run_test(1'b1);
    tick(1'b1, 1'b0);
    chk("R3 weak captured", batt_low_n, 1'b0);

    // reset with power held high
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 reset clears flag", batt_low_n, 1'b1);
    chk("R8 reset clears request", cmp_en, 1'b0);
    exp_low = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 request low at release", cmp_en, 1'b0);
    run_test(1'b1);
    gap(IV);
    run_test(1'b0);
    tick(1'b1, 1'b1);
    chk("R9 release after good test", batt_low_n, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule